// File: doc/BRIEF.md
# Integer Decode and Execute Unit

This unit is the combinational heart of a single-cycle integer datapath. It takes one 32-bit instruction word together with the two values already read from the register file. In the same cycle it returns the register indices, a write strobe and a 32-bit result. It recognises a small integer subset:

- register-register add, subtract, OR, XOR and the three shifts;
- add, AND and OR with a 12-bit immediate;
- placing an upper immediate.

The surrounding pipeline uses the two source indices to address the register file. It feeds the read values back in, then writes `result` to the register named by `rd_idx` whenever `wr_en` is high.

The unit holds no state and has no clock. Every output settles from the current inputs alone. The instruction stream therefore has no valid/ready handshake at this boundary: the caller owns flow control and back-pressure, and simply stops presenting words when it is stalled. An encoding outside the subset does not write the register file. Instead it raises `illegal` so that the caller can trap.

Top module: `intdec_exec`

## Requirements
- R1: `rd_idx` equals instruction bits [11:7], `rs1_idx` equals bits [19:15] and `rs2_idx` equals bits [24:20], for every instruction word.
- R2: With major opcode 0110011 and funct3 000, funct7 0000000 yields rs1+rs2 and funct7 0100000 yields rs1-rs2. Both wrap modulo 2^32.
- R3: With major opcode 0110011 and funct7 0000000, funct3 110 yields rs1 OR rs2 and funct3 100 yields rs1 XOR rs2.
- R4: With major opcode 0110011, the shift amount is the low 5 bits of rs2. The three shifts are selected as follows:
  - funct3 001 with funct7 0000000 shifts left and fills with zeros;
  - funct3 101 with funct7 0000000 shifts right and fills with zeros;
  - funct3 101 with funct7 0100000 shifts right and fills with copies of bit 31.
- R5: With opcode 0010011 and funct3 000, the result is rs1 plus bits [31:20] sign-extended to 32 bits.
- R6: With opcode 0010011, funct3 111 yields rs1 AND the zero-extended bits [31:20], and funct3 110 yields rs1 OR the same zero-extended immediate.
- R7: With opcode 0110111, the result is the 20-bit field in bits [31:12] shifted left by 16 and truncated to 32 bits. The low 16 bits of the result are therefore zero.
- R8: Any other combination raises `illegal`, forces `wr_en` low and drives `result` to zero. This covers any other opcode, any other funct3 under the two arithmetic opcodes, and any other funct7 under opcode 0110011.
- R9: `wr_en` is high exactly when the instruction is legal and `rd_idx` is nonzero. When `rd_idx` is zero, `illegal` is unaffected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| instr | input | 32 | Instruction word |
| rs1_val | input | 32 | Value read at `rs1_idx` |
| rs2_val | input | 32 | Value read at `rs2_idx` |
| rs1_idx | output | 5 | First source register index |
| rs2_idx | output | 5 | Second source register index |
| rd_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write strobe |
| result | output | 32 | Value to write |
| illegal | output | 1 | Unsupported encoding |

## Verification
Because the unit is combinational, a wrong decode shows up in the same cycle the word is presented. It appears as a wrong `result`, a write strobe on an illegal or rd-zero word, or a legal word flagged `illegal`. A wrong extension mode shows mainly on immediates with bit 31 set, so the stimulus forces that bit often. Shift mis-selection shows on negative operands and on rs2 values above 31. The bench drives a mix of directed corner words and random words drawn from the legal set and its near neighbours. It compares all outputs against a behavioural model once per clock.

// File: rtl/intdec_pkg.sv
package intdec_pkg;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_UPPER = 7'b0110111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ADD, ALU_SUB, ALU_OR, ALU_XOR, ALU_AND,
    ALU_SLL, ALU_SRL, ALU_SRA, ALU_PASS
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_NONE, IMM_SEXT, IMM_ZEXT, IMM_UPPER
  } imm_kind_e;
endpackage

// File: rtl/intdec_ctrl.sv
module intdec_ctrl
  import intdec_pkg::*;
(
  input  logic [31:0] instr,
  output alu_op_e     op,
  output imm_kind_e   imm_kind,
  output logic        bad
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign f7  = instr[31:25];

  always_comb begin
    op       = ALU_PASS;
    imm_kind = IMM_NONE;
    bad      = 1'b1;
    unique case (opc)
      OPC_REG: begin
        case (f3)
          3'b000: begin
            if (f7 == F7_BASE)     begin op = ALU_ADD; bad = 1'b0; end
            else if (f7 == F7_ALT) begin op = ALU_SUB; bad = 1'b0; end
          end
          3'b110: if (f7 == F7_BASE) begin op = ALU_OR;  bad = 1'b0; end
          3'b100: if (f7 == F7_BASE) begin op = ALU_XOR; bad = 1'b0; end
          3'b001: if (f7 == F7_BASE) begin op = ALU_SLL; bad = 1'b0; end
          3'b101: begin
            if (f7 == F7_BASE)     begin op = ALU_SRL; bad = 1'b0; end
            else if (f7 == F7_ALT) begin op = ALU_SRA; bad = 1'b0; end
          end
          default: ;
        endcase
      end
      OPC_IMM: begin
        case (f3)
          3'b000: begin op = ALU_ADD; imm_kind = IMM_SEXT; bad = 1'b0; end
          3'b111: begin op = ALU_AND; imm_kind = IMM_ZEXT; bad = 1'b0; end
          3'b110: begin op = ALU_OR;  imm_kind = IMM_ZEXT; bad = 1'b0; end
          default: ;
        endcase
      end
      OPC_UPPER: begin op = ALU_PASS; imm_kind = IMM_UPPER; bad = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/intdec_immgen.sv
module intdec_immgen
  import intdec_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int SHORT_W     = 12,
  parameter int LONG_W      = 20,
  parameter int UPPER_SHIFT = 16
) (
  input  logic [31:0]     instr,
  input  imm_kind_e       kind,
  input  logic [XLEN-1:0] reg_val,
  output logic [XLEN-1:0] operand
);
  localparam int SHORT_LSB = 32 - SHORT_W;
  localparam int LONG_LSB  = 32 - LONG_W;

  logic [SHORT_W-1:0] short_f;
  logic [LONG_W-1:0]  long_f;
  logic [XLEN-1:0]    sext_v, zext_v, upper_v;

  assign short_f = instr[31:SHORT_LSB];
  assign long_f  = instr[31:LONG_LSB];
  assign sext_v  = {{(XLEN-SHORT_W){short_f[SHORT_W-1]}}, short_f};
  assign zext_v  = {{(XLEN-SHORT_W){1'b0}}, short_f};
  assign upper_v = {{(XLEN-LONG_W){1'b0}}, long_f} << UPPER_SHIFT;

  always_comb begin
    case (kind)
      IMM_SEXT:  operand = sext_v;
      IMM_ZEXT:  operand = zext_v;
      IMM_UPPER: operand = upper_v;
      default:   operand = reg_val;
    endcase
  end
endmodule

// File: rtl/intdec_alu.sv
module intdec_alu
  import intdec_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e         op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  localparam int SH_W = $clog2(XLEN);

  logic [SH_W-1:0] sh;
  assign sh = b[SH_W-1:0];

  always_comb begin
    case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_OR:   y = a | b;
      ALU_XOR:  y = a ^ b;
      ALU_AND:  y = a & b;
      ALU_SLL:  y = a << sh;
      ALU_SRL:  y = a >> sh;
      ALU_SRA:  y = XLEN'($signed(a) >>> sh);
      default:  y = b;
    endcase
  end
endmodule

// File: rtl/intdec_exec.sv
module intdec_exec
  import intdec_pkg::*;
#(
  parameter int XLEN  = 32,
  parameter int IDX_W = 5
) (
  input  logic [31:0]      instr,
  input  logic [XLEN-1:0]  rs1_val,
  input  logic [XLEN-1:0]  rs2_val,
  output logic [IDX_W-1:0] rs1_idx,
  output logic [IDX_W-1:0] rs2_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [XLEN-1:0]  result,
  output logic             illegal
);
  alu_op_e         op;
  imm_kind_e       kind;
  logic            bad;
  logic [XLEN-1:0] opnd_b, alu_y;

  assign rd_idx  = instr[7 +: IDX_W];
  assign rs1_idx = instr[15 +: IDX_W];
  assign rs2_idx = instr[20 +: IDX_W];

  intdec_ctrl u_ctrl (
    .instr    (instr),
    .op       (op),
    .imm_kind (kind),
    .bad      (bad)
  );

  intdec_immgen #(.XLEN(XLEN)) u_imm (
    .instr   (instr),
    .kind    (kind),
    .reg_val (rs2_val),
    .operand (opnd_b)
  );

  intdec_alu #(.XLEN(XLEN)) u_alu (
    .op (op),
    .a  (rs1_val),
    .b  (opnd_b),
    .y  (alu_y)
  );

  assign illegal = bad;
  assign wr_en   = !bad && (rd_idx != '0);
  assign result  = bad ? '0 : alu_y;
endmodule

// File: rtl/intdec_exec_chk.sv
module intdec_exec_chk (
  input logic [31:0] instr,
  input logic [31:0] rs1_val,
  input logic [4:0]  rd_idx,
  input logic        wr_en,
  input logic [31:0] result,
  input logic        illegal
);
  always_comb begin
    // R8
    illegal_quiet_chk: assert (!illegal || (!wr_en && result == 32'h0));
    // R9
    rd_zero_nowrite_chk: assert (rd_idx != 5'd0 || !wr_en);
    // R7
    upper_low_clear_chk: assert (instr[6:0] != 7'b0110111 || (!illegal && result[15:0] == 16'h0));
    // R6
    andi_subset_chk: assert (!(instr[6:0] == 7'b0010011 && instr[14:12] == 3'b111) || (result & ~rs1_val) == 32'h0);
    // R6
    ori_superset_chk: assert (!(instr[6:0] == 7'b0010011 && instr[14:12] == 3'b110) || (result & rs1_val) == rs1_val);
  end
endmodule

bind intdec_exec intdec_exec_chk u_chk (
  .instr   (instr),
  .rs1_val (rs1_val),
  .rd_idx  (rd_idx),
  .wr_en   (wr_en),
  .result  (result),
  .illegal (illegal)
);

// File: tb/intdec_exec_tb_top.sv
module intdec_exec_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr = 32'h0;
  logic [31:0] rs1_val = 32'h0;
  logic [31:0] rs2_val = 32'h0;
  logic [4:0]  rs1_idx, rs2_idx, rd_idx;
  logic        wr_en, illegal;
  logic [31:0] result;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  intdec_exec dut_i (
    .instr(instr), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .rs1_idx(rs1_idx), .rs2_idx(rs2_idx), .rd_idx(rd_idx),
    .wr_en(wr_en), .result(result), .illegal(illegal)
  );

  // reference model results
  logic [31:0] m_res;
  logic        m_ill;
  string       m_tag;

  task automatic model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    int unsigned opc = w[6:0];
    int unsigned f3  = w[14:12];
    int unsigned f7  = w[31:25];
    int unsigned sh  = b % 32;
    int          sa;
    int          im;
    m_ill = 1; m_res = 0; m_tag = "R8";
    if (opc == 'h33) begin
      if (f3 == 0 && f7 == 0)         begin m_res = a + b; m_ill = 0; m_tag = "R2"; end
      else if (f3 == 0 && f7 == 'h20) begin m_res = a - b; m_ill = 0; m_tag = "R2"; end
      else if (f3 == 6 && f7 == 0)     begin m_res = a | b; m_ill = 0; m_tag = "R3"; end
      else if (f3 == 4 && f7 == 0)     begin m_res = a ^ b; m_ill = 0; m_tag = "R3"; end
      else if (f3 == 1 && f7 == 0)     begin m_res = a << sh; m_ill = 0; m_tag = "R4"; end
      else if (f3 == 5 && f7 == 0)     begin m_res = a >> sh; m_ill = 0; m_tag = "R4"; end
      else if (f3 == 5 && f7 == 'h20) begin sa = a; m_res = sa >>> sh; m_ill = 0; m_tag = "R4"; end
    end else if (opc == 'h13) begin
      im = int'(w[31:20]);
      if (f3 == 0) begin
        if (im >= 2048) im = im - 4096;
        m_res = a + im; m_ill = 0; m_tag = "R5";
      end else if (f3 == 7) begin m_res = a & im; m_ill = 0; m_tag = "R6"; end
      else if (f3 == 6)     begin m_res = a | im; m_ill = 0; m_tag = "R6"; end
    end else if (opc == 'h37) begin
      m_res = w[31:12] * 65536; m_ill = 0; m_tag = "R7";
    end
  endtask

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s instr=%h actual=%h expected=%h", tag, what, instr, act, exp);
    end
  endtask

  task automatic compare_all();
    logic exp_we;
    model(instr, rs1_val, rs2_val);
    exp_we = !m_ill && instr[11:7] != 0;
    check(rd_idx == instr[11:7] && rs1_idx == instr[19:15] && rs2_idx == instr[24:20],
          "R1", "indices", {17'h0, rd_idx, rs1_idx, rs2_idx}, {17'h0, instr[11:7], instr[19:15], instr[24:20]});
    check(illegal == m_ill, "R8", "illegal", 32'(illegal), 32'(m_ill));
    check(wr_en == exp_we, (instr[11:7] == 0) ? "R9" : m_tag, "wr_en", 32'(wr_en), 32'(exp_we));
    check(result == m_res, m_tag, "result", result, m_res);
  endtask

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    #1;
    instr = w; rs1_val = a; rs2_val = b;
    @(negedge clk);
    compare_all();
  endtask

  function automatic logic [31:0] rtype(input int f7, input int f3, input int rd);
    return {7'(f7), 5'd3, 5'd4, 3'(f3), 5'(rd), 7'h33};
  endfunction

  function automatic logic [31:0] itype(input int imm, input int f3, input int rd);
    return {12'(imm), 5'd6, 3'(f3), 5'(rd), 7'h13};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // idle state: all-zero word is not in the subset (R8)
    compare_all();

    // R2 add / sub with wrap
    apply(rtype(0, 0, 5), 32'hFFFF_FFFF, 32'h2);
    apply(rtype('h20, 0, 5), 32'h0, 32'h1);
    // R3
    apply(rtype(0, 6, 9), 32'hF0F0_0000, 32'h0F0F_1234);
    apply(rtype(0, 4, 9), 32'hAAAA_5555, 32'hFFFF_0000);
    // R4 shifts: big amounts, low 5 bits only, negative operand
    apply(rtype(0, 1, 1), 32'h8000_0001, 32'd31);
    apply(rtype(0, 5, 1), 32'h8000_0000, 32'd31);
    apply(rtype('h20, 5, 1), 32'h8000_0000, 32'd31);
    apply(rtype('h20, 5, 1), 32'h8765_4321, 32'h0000_0024);
    apply(rtype(0, 5, 1), 32'h8765_4321, 32'hFFFF_FFE4);
    // R5 sign extension
    apply(itype('hFFF, 0, 7), 32'h10, 32'h0);
    apply(itype('h800, 0, 7), 32'h0, 32'h0);
    // R6 zero extension
    apply(itype('hFFF, 7, 7), 32'hFFFF_FFFF, 32'h0);
    apply(itype('h800, 6, 7), 32'h0, 32'h0);
    // R7 upper
    apply({20'hFFFFF, 5'd2, 7'h37}, 32'h0, 32'h0);
    apply({20'h12345, 5'd2, 7'h37}, 32'h0, 32'h0);
    // R8 illegal funct7 / funct3 / opcode
    apply(rtype('h20, 6, 5), 32'h1, 32'h2);
    apply(rtype(0, 2, 5), 32'h1, 32'h2);
    apply(itype(5, 1, 5), 32'h1, 32'h2);
    apply(32'h0000_0283, 32'h1, 32'h2);
    // R9 rd zero
    apply(rtype(0, 0, 0), 32'h1, 32'h2);
    apply({20'h1, 5'd0, 7'h37}, 32'h0, 32'h0);

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] w;
      int sel;
      w = $urandom;
      sel = $urandom_range(0, 9);
      if (sel < 4) w[6:0] = 7'h33;
      else if (sel < 7) w[6:0] = 7'h13;
      else if (sel < 8) w[6:0] = 7'h37;
      if (w[6:0] == 7'h33) begin
        sel = $urandom_range(0, 4);
        if (sel < 2) w[31:25] = 7'h00;
        else if (sel < 4) w[31:25] = 7'h20;
      end
      if ($urandom_range(0, 7) == 0) w[11:7] = 5'd0;
      apply(w, $urandom, $urandom);
    end
    done = 1;
  end

  initial begin
    while (!done && cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule